// File: doc/BRIEF.md
# Integer Condition Code Generator

This block turns the outcome of an integer operation into the four processor condition flags: negative, zero, overflow and carry. The execution datapath computes the arithmetic result elsewhere. It hands this block the operation class, the operand size, both source operands, the result, the flags currently in force and the overflow-trap enable. On every cycle with `op_valid` high, the new flags are registered. In the same cycle, a one-cycle trap request is raised if an enabled arithmetic overflow occurred.

Five classes are supported. Move/test sets flags from the result alone. A carry-keeping variant of move/test leaves the carry as it was. Add and subtract derive overflow and carry from the sign and magnitude relations of the sized operands. Compare relates the two operands directly and ignores the result. Byte, word, longword and quadword sizes are selected by a two-bit code. Operands arrive zero-extended on a `DATA_W`-bit bus, and bits above the selected size play no part.

Top module: `icc_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `flags_q` to 4'b0000 and `ovf_trap` to 0.
- R2: At a rising edge with `op_valid` low, `flags_q` keeps its value and `ovf_trap` is 0.
- R3: Class code 0 (move/test) gives flag vector {N,Z,V,C} in `flags_q[3:0]`. N is the sign bit of the sized result: `res_lo` bit 7 for size code 0 (byte), bit 15 for code 1 (word), bit 31 for code 2 (longword), and `res_hi` bit 31 for code 3 (quadword). Z is 1 when the sized result is zero; for quadword, Z needs both low 32-bit halves to be zero. V and C are 0.
- R4: Class code 1 (carry-keeping move/test) sets N and Z as in R3 and clears V. C takes the value `prev_flags[0]`.
- R5: Class code 2 (add) takes N and Z from the sized result. V is the size sign bit of (~s1 ^ s2) & (s1 ^ r). C is 1 when r < s2, compared as unsigned sized values.
- R6: Class code 3 (subtract) takes N and Z from the sized result. V is the size sign bit of (s1 ^ s2) & (~s1 ^ r). C is 1 when s2 < s1, compared as unsigned sized values.
- R7: Class code 4 (compare) sets N when s1 < s2 after sign extension from the size, and Z when the sized operands are equal. V is 0. C is set when s1 < s2 as unsigned values. The result inputs are ignored.
- R8: Operand and result bits above the selected size have no effect on the flags.
- R9: With size code 3, the add, subtract and compare classes use longword rules on `src1`, `src2` and `res_lo`, and `res_hi` is ignored.
- R10: `ovf_trap` is 1 for exactly the cycle after an edge that registered an add or subtract whose V is 1 while `ovf_enable` was 1. It is 0 in every other cycle.
- R11: Class codes 5 to 7 copy `prev_flags` into `flags_q` and never raise `ovf_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Register new flags this cycle |
| op_class | input | 3 | Operation class code (0 test, 1 test keep carry, 2 add, 3 subtract, 4 compare) |
| op_size | input | 2 | Size code (0 byte, 1 word, 2 longword, 3 quadword) |
| src1 | input | DATA_W | First source operand, zero-extended |
| src2 | input | DATA_W | Second source operand, zero-extended |
| res_lo | input | DATA_W | Result, low half |
| res_hi | input | DATA_W | Result, high half (quadword move/test only) |
| prev_flags | input | 4 | Flags currently in force {N,Z,V,C} |
| ovf_enable | input | 1 | Integer overflow trap enable from the status word |
| flags_q | output | 4 | Registered flags {N,Z,V,C} |
| ovf_trap | output | 1 | One-cycle integer overflow trap request |

## Verification
Both results of an operation presented with `op_valid` high are due on the first rising edge after it: `flags_q` and `ovf_trap` change together on that edge and on no other. The bench drives every input on a falling edge. It compares both outputs on the next falling edge against a bench model that has been advanced by the same operation. Each comparison therefore lands half a period after the one edge that could change the outputs. Idle cycles in the random stream check that the outputs hold and that the trap request clears one cycle after it was raised.

// File: rtl/icc_pkg.sv
package icc_pkg;

   localparam int FLAG_W     = 4;
   localparam int LANE_BASE_W = 8;
   localparam int LONG_W     = 32;
   localparam int N_LANES    = 3;

   typedef enum logic [2:0] {
      CLS_TEST    = 3'd0,
      CLS_TEST_KC = 3'd1,
      CLS_ADD     = 3'd2,
      CLS_SUB     = 3'd3,
      CLS_CMP     = 3'd4
   } icc_class_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_QUAD = 2'd3
   } icc_size_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } icc_flags_t;

endpackage

// File: rtl/icc_operand_view.sv
module icc_operand_view
   import icc_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] src1_i,
   input  logic [DATA_W-1:0] src2_i,
   input  logic [DATA_W-1:0] res_lo_i,
   input  logic [DATA_W-1:0] res_hi_i,
   output logic [DATA_W-1:0] a_o,
   output logic [DATA_W-1:0] b_o,
   output logic [DATA_W-1:0] r_o,
   output logic              a_sgn_o,
   output logic              b_sgn_o,
   output logic              r_sgn_o,
   output logic              test_neg_o,
   output logic              test_zero_o
);

   logic [DATA_W-1:0] lane_mask [N_LANES];
   logic [N_LANES-1:0] lane_a_sgn;
   logic [N_LANES-1:0] lane_b_sgn;
   logic [N_LANES-1:0] lane_r_sgn;
   logic [1:0]         lane_sel;
   logic [DATA_W-1:0]  long_mask;

   // One lane per architectural size; the quadword arithmetic case reuses the longword lane.
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int LW = LANE_BASE_W << g;
      assign lane_mask[g]  = {DATA_W{1'b1}} >> (DATA_W - LW);
      assign lane_a_sgn[g] = src1_i[LW-1];
      assign lane_b_sgn[g] = src2_i[LW-1];
      assign lane_r_sgn[g] = res_lo_i[LW-1];
   end

   assign lane_sel  = (icc_size_e'(size_i) == SZ_QUAD) ? 2'd2 : size_i;
   assign long_mask = lane_mask[2];

   assign a_o     = src1_i   & lane_mask[lane_sel];
   assign b_o     = src2_i   & lane_mask[lane_sel];
   assign r_o     = res_lo_i & lane_mask[lane_sel];
   assign a_sgn_o = lane_a_sgn[lane_sel];
   assign b_sgn_o = lane_b_sgn[lane_sel];
   assign r_sgn_o = lane_r_sgn[lane_sel];

   always_comb begin
      if (icc_size_e'(size_i) == SZ_QUAD) begin
         test_neg_o  = res_hi_i[LONG_W-1];
         test_zero_o = ((res_lo_i & long_mask) | (res_hi_i & long_mask)) == '0;
      end else begin
         test_neg_o  = r_sgn_o;
         test_zero_o = (r_o == '0);
      end
   end

endmodule

// File: rtl/icc_arith_flags.sv
module icc_arith_flags
   import icc_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] r_i,
   input  logic              a_sgn_i,
   input  logic              b_sgn_i,
   input  logic              r_sgn_i,
   output icc_flags_t        add_o,
   output icc_flags_t        sub_o,
   output icc_flags_t        cmp_o
);

   logic r_zero;
   logic a_lt_b_u;
   logic b_lt_a_u;
   logic r_lt_b_u;
   logic a_lt_b_s;

   assign r_zero   = (r_i == '0);
   assign a_lt_b_u = (a_i < b_i);
   assign b_lt_a_u = (b_i < a_i);
   assign r_lt_b_u = (r_i < b_i);
   // Signed order from the sign bits plus the unsigned order of equal-sign operands.
   assign a_lt_b_s = (a_sgn_i != b_sgn_i) ? a_sgn_i : a_lt_b_u;

   assign add_o = '{n: r_sgn_i, z: r_zero,
                    v: (~a_sgn_i ^ b_sgn_i) & (a_sgn_i ^ r_sgn_i),
                    c: r_lt_b_u};

   assign sub_o = '{n: r_sgn_i, z: r_zero,
                    v: (a_sgn_i ^ b_sgn_i) & (~a_sgn_i ^ r_sgn_i),
                    c: b_lt_a_u};

   assign cmp_o = '{n: a_lt_b_s, z: (a_i == b_i), v: 1'b0, c: a_lt_b_u};

endmodule

// File: rtl/icc_flag_select.sv
module icc_flag_select
   import icc_pkg::*;
(
   input  logic [2:0]  class_i,
   input  logic        test_neg_i,
   input  logic        test_zero_i,
   input  icc_flags_t  prev_i,
   input  icc_flags_t  add_i,
   input  icc_flags_t  sub_i,
   input  icc_flags_t  cmp_i,
   input  logic        ovf_en_i,
   output icc_flags_t  next_o,
   output logic        trap_o
);

   always_comb begin
      next_o = prev_i;
      trap_o = 1'b0;
      case (icc_class_e'(class_i))
         CLS_TEST:    next_o = '{n: test_neg_i, z: test_zero_i, v: 1'b0, c: 1'b0};
         CLS_TEST_KC: next_o = '{n: test_neg_i, z: test_zero_i, v: 1'b0, c: prev_i.c};
         CLS_ADD: begin
            next_o = add_i;
            trap_o = add_i.v & ovf_en_i;
         end
         CLS_SUB: begin
            next_o = sub_i;
            trap_o = sub_i.v & ovf_en_i;
         end
         CLS_CMP:     next_o = cmp_i;
         default:     next_o = prev_i;
      endcase
   end

endmodule

// File: rtl/icc_gen.sv
module icc_gen
   import icc_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [2:0]        op_class,
   input  logic [1:0]        op_size,
   input  logic [DATA_W-1:0] src1,
   input  logic [DATA_W-1:0] src2,
   input  logic [DATA_W-1:0] res_lo,
   input  logic [DATA_W-1:0] res_hi,
   input  logic [3:0]        prev_flags,
   input  logic              ovf_enable,
   output logic [3:0]        flags_q,
   output logic              ovf_trap
);

   if (DATA_W < LONG_W) begin : g_bad_width
      $error("icc_gen: DATA_W must hold a longword");
   end
   if (FLAG_W != 4) begin : g_bad_flags
      $error("icc_gen: flag vector must be four bits");
   end

   logic [DATA_W-1:0] a_m, b_m, r_m;
   logic              a_sgn, b_sgn, r_sgn;
   logic              test_neg, test_zero;
   icc_flags_t        add_f, sub_f, cmp_f, next_f;
   logic              trap_next;

   icc_operand_view #(.DATA_W(DATA_W)) u_view (
      .size_i      (op_size),
      .src1_i      (src1),
      .src2_i      (src2),
      .res_lo_i    (res_lo),
      .res_hi_i    (res_hi),
      .a_o         (a_m),
      .b_o         (b_m),
      .r_o         (r_m),
      .a_sgn_o     (a_sgn),
      .b_sgn_o     (b_sgn),
      .r_sgn_o     (r_sgn),
      .test_neg_o  (test_neg),
      .test_zero_o (test_zero)
   );

   icc_arith_flags #(.DATA_W(DATA_W)) u_arith (
      .a_i     (a_m),
      .b_i     (b_m),
      .r_i     (r_m),
      .a_sgn_i (a_sgn),
      .b_sgn_i (b_sgn),
      .r_sgn_i (r_sgn),
      .add_o   (add_f),
      .sub_o   (sub_f),
      .cmp_o   (cmp_f)
   );

   icc_flag_select u_sel (
      .class_i     (op_class),
      .test_neg_i  (test_neg),
      .test_zero_i (test_zero),
      .prev_i      (icc_flags_t'(prev_flags)),
      .add_i       (add_f),
      .sub_i       (sub_f),
      .cmp_i       (cmp_f),
      .ovf_en_i    (ovf_enable),
      .next_o      (next_f),
      .trap_o      (trap_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q  <= '0;
         ovf_trap <= 1'b0;
      end else if (op_valid) begin
         flags_q  <= next_f;
         ovf_trap <= trap_next;
      end else begin
         ovf_trap <= 1'b0;
      end
   end

   // R2: idle cycles hold the flags and drop the trap request
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> ($stable(flags_q) && !ovf_trap));

   // R3: move/test never reports overflow or carry, and N and Z cannot both hold
   assert_test_clears_vc_R3: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_class == 3'd0) |=> (flags_q[1:0] == 2'b00 && !(flags_q[3] && flags_q[2])));

   // R4: the carry-keeping variant passes the old carry through
   assert_keep_carry_R4: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_class == 3'd1) |=> (flags_q[0] == $past(prev_flags[0]) && !flags_q[1]));

   // R7: compare never sets V
   assert_cmp_no_v_R7: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_class == 3'd4) |=> !flags_q[1]);

   // R10: a trap request comes only with V, from an enabled add or subtract
   assert_trap_source_R10: assert property (@(posedge clk) disable iff (rst)
      ovf_trap |-> (flags_q[1] && $past(ovf_enable) && $past(op_valid)
                    && ($past(op_class) == 3'd2 || $past(op_class) == 3'd3)));

   // R10: the trap request lasts one cycle unless the next operation overflows again
   assert_trap_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      (ovf_trap && !op_valid) |=> !ovf_trap);

   // R11: unused class codes copy the incoming flags
   assert_unused_copy_R11: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_class > 3'd4) |=> (flags_q == $past(prev_flags) && !ovf_trap));

endmodule

// File: tb/tb_icc_gen.sv
module tb_icc_gen;

   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst;
   logic              op_valid;
   logic [2:0]        op_class;
   logic [1:0]        op_size;
   logic [DATA_W-1:0] src1, src2, res_lo, res_hi;
   logic [3:0]        prev_flags;
   logic              ovf_enable;
   logic [3:0]        flags_q;
   logic              ovf_trap;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done     = 1'b0;
   logic [3:0] exp_flags;
   logic       exp_trap;

   always #4 clk = ~clk;

   icc_gen #(.DATA_W(DATA_W)) dut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
      .op_size(op_size), .src1(src1), .src2(src2), .res_lo(res_lo),
      .res_hi(res_hi), .prev_flags(prev_flags), .ovf_enable(ovf_enable),
      .flags_q(flags_q), .ovf_trap(ovf_trap)
   );

   // Returns {trap, N, Z, V, C} from the requirement formulas.
   function automatic logic [4:0] ref_model(input logic [2:0] cls, input logic [1:0] sz,
                                            input logic [31:0] s1, input logic [31:0] s2,
                                            input logic [31:0] rl, input logic [31:0] rh,
                                            input logic [3:0] pf, input logic en);
      int w;
      logic [63:0] m, sb, a, b, r;
      longint sa, sbv;
      logic n, z, v, c;
      w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      m  = (64'd1 << w) - 64'd1;
      sb = 64'd1 << (w - 1);
      a  = {32'd0, s1} & m;
      b  = {32'd0, s2} & m;
      r  = {32'd0, rl} & m;
      n  = (r & sb) != 0;
      z  = (r == 0);
      v  = 1'b0;
      c  = 1'b0;
      case (cls)
         3'd0, 3'd1: begin
            if (sz == 2'd3) begin
               n = rh[31];
               z = ({rh, rl} == 64'd0);
            end
            if (cls == 3'd1) c = pf[0];
         end
         3'd2: begin
            v = ((~a ^ b) & (a ^ r) & sb) != 0;
            c = r < b;
         end
         3'd3: begin
            v = ((a ^ b) & (~a ^ r) & sb) != 0;
            c = b < a;
         end
         3'd4: begin
            sa  = longint'(a);
            sbv = longint'(b);
            if ((a & sb) != 0) sa  = sa  - longint'(m) - 1;
            if ((b & sb) != 0) sbv = sbv - longint'(m) - 1;
            n = sa < sbv;
            z = (a == b);
            c = a < b;
         end
         default: return {1'b0, pf};
      endcase
      return {((cls == 3'd2) || (cls == 3'd3)) && v && en, n, z, v, c};
   endfunction

   function automatic string tag_of(input logic [2:0] cls);
      case (cls)
         3'd0:    return "R3";
         3'd1:    return "R4";
         3'd2:    return "R5";
         3'd3:    return "R6";
         3'd4:    return "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input logic [3:0] gf, input logic gt);
      n_checks++;
      if (gf !== exp_flags || gt !== exp_trap) begin
         n_errors++;
         $display("FAIL %s: flags=%b trap=%b expected flags=%b trap=%b",
                  tag, gf, gt, exp_flags, exp_trap);
      end
   endtask

   // Drive on a falling edge; the outputs are due at the next rising edge, checked a half period later.
   task automatic op(input string tag, input logic vld, input logic [2:0] cls, input logic [1:0] sz,
                     input logic [31:0] s1, input logic [31:0] s2, input logic [31:0] rl,
                     input logic [31:0] rh, input logic [3:0] pf, input logic en);
      logic [4:0] rv;
      op_valid = vld; op_class = cls; op_size = sz; src1 = s1; src2 = s2;
      res_lo = rl; res_hi = rh; prev_flags = pf; ovf_enable = en;
      rv = ref_model(cls, sz, s1, s2, rl, rh, pf, en);
      if (vld) begin
         exp_flags = rv[3:0];
         exp_trap  = rv[4];
      end else begin
         exp_trap  = 1'b0;
      end
      @(negedge clk);
      check(tag, flags_q, ovf_trap);
   endtask

   initial begin
      rst = 1'b1; op_valid = 1'b0; op_class = '0; op_size = '0; src1 = '0; src2 = '0;
      res_lo = '0; res_hi = '0; prev_flags = '0; ovf_enable = 1'b0;
      exp_flags = 4'b0000; exp_trap = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset", flags_q, ovf_trap);
      rst = 1'b0;

      // R5 R10: byte add 0x7F + 0x01 overflows, trap enabled
      op("R5 byte add overflow", 1, 3'd2, 2'd0, 32'h7F, 32'h01, 32'h80, 0, 4'h0, 1);
      if (exp_flags !== 4'b1010) $display("FAIL R5 bench model flags=%b expected=1010", exp_flags);
      op("R10 trap drops when idle / R2 hold", 0, 3'd2, 2'd0, 0, 0, 0, 0, 4'hF, 1);
      op("R10 no trap when disabled", 1, 3'd2, 2'd0, 32'h7F, 32'h01, 32'h80, 0, 4'h0, 0);
      // R6: word 0 - 1 borrows, no overflow
      op("R6 word borrow", 1, 3'd3, 2'd1, 32'h1, 32'h0, 32'hFFFF, 0, 4'h0, 1);
      // R6 R10: word 0x8000 - 1 overflows
      op("R6 word sub overflow", 1, 3'd3, 2'd1, 32'h1, 32'h8000, 32'h7FFF, 0, 4'h0, 1);
      // R7 R8: byte compare -128 vs 1 with junk above the byte
      op("R7 R8 signed compare", 1, 3'd4, 2'd0, 32'hFFFFFF80, 32'hABCD0001, 32'h5A5A5A5A, 0, 4'h0, 1);
      op("R7 equal compare", 1, 3'd4, 2'd2, 32'h12345678, 32'h12345678, 0, 0, 4'hF, 1);
      // R3: quadword sign and zero from both halves
      op("R3 quad negative", 1, 3'd0, 2'd3, 0, 0, 32'h0, 32'h80000000, 4'h0, 0);
      op("R3 quad zero", 1, 3'd0, 2'd3, 0, 0, 32'h0, 32'h0, 4'hF, 0);
      op("R3 quad nonzero high", 1, 3'd0, 2'd3, 0, 0, 32'h0, 32'h1, 4'h0, 0);
      // R8: word test ignores bits above 15
      op("R8 word test junk above size", 1, 3'd0, 2'd1, 0, 0, 32'hFFFF0000, 32'hFFFFFFFF, 4'h0, 0);
      // R4: carry kept
      op("R4 keep carry", 1, 3'd1, 2'd0, 0, 0, 32'h00000100, 0, 4'b0001, 0);
      op("R4 keep carry clear", 1, 3'd1, 2'd2, 0, 0, 32'h80000000, 0, 4'b1110, 0);
      // R9: quadword add uses longword rules, high result ignored
      op("R9 quad add as longword", 1, 3'd2, 2'd3, 32'hFFFFFFFF, 32'h1, 32'h0, 32'hFFFFFFFF, 4'h0, 1);
      // R11: unused code copies previous flags
      op("R11 unused class", 1, 3'd6, 2'd0, 32'h7F, 32'h1, 32'h80, 0, 4'b1011, 1);
      // R1: reset mid-run with valid high
      op("R5 setup before reset", 1, 3'd2, 2'd2, 32'h7FFFFFFF, 32'h1, 32'h80000000, 0, 4'h0, 1);
      rst = 1'b1;
      exp_flags = 4'b0000; exp_trap = 1'b0;
      @(negedge clk);
      check("R1 reset during operation", flags_q, ovf_trap);
      rst = 1'b0;

      // Constrained random stream
      void'($urandom(32'd2024));
      for (int i = 0; i < 4000; i++) begin
         logic [2:0]  cls;
         logic [1:0]  sz;
         logic [31:0] s1, s2, rl, rh;
         logic        vld;
         cls = ($urandom % 16 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
         sz  = 2'($urandom % 4);
         s1  = $urandom;
         s2  = $urandom;
         if ($urandom % 4 == 0) s1 = s1 & 32'h000000FF;
         case (cls)
            3'd2:    rl = s1 + s2;
            3'd3:    rl = s2 - s1;
            default: rl = ($urandom % 4 == 0) ? 32'h0 : $urandom;
         endcase
         rh  = ($urandom % 3 == 0) ? 32'h0 : $urandom;
         vld = ($urandom % 8) != 0;
         op(vld ? tag_of(cls) : "R2", vld, cls, sz, s1, s2, rl, rh, 4'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule